// File: doc/BRIEF.md
# ADC Conversion Interrupt Controller

This block sits between an A/D conversion sequencer and the interrupt fabric of a chip. It takes pulses that mark the end of a single-channel conversion, a subgroup and a full cycle. Each pulse sets a sticky raw flag. A single-channel completion also carries a channel index and a 12-bit result, which the block stores in that channel's result register and marks as valid.

Reading a result register consumes it. A result that lands on an unread register raises an overwrite flag. A threshold watchdog can be switched on to flag results that fall strictly outside a programmed window.

Software sees the flags through four registers: a flag enable register, a raw register, a masked status register and a write-one-to-clear register. One interrupt line is the OR of every enabled raw flag.

Top module: `adc_irq_ctrl`

## Requirements
- R1: The raw register (offset 1) holds three completion flags. Bit 0 is set by a single-sample done pulse, bit 1 by a subgroup done pulse and bit 2 by a cycle done pulse. Each flag is set in the cycle after its pulse.
- R2: Raw flags are sticky and do not depend on the enables (offset 0, same bit layout). The status register (offset 2) reads raw AND enable. `irqReq` is high exactly when some status bit is 1.
- R3: A sample done pulse stores `evtData` in the result register of channel `evtCh` and sets that channel's valid flag. The result register of channel n is at offset 8+n and reads as {valid at bit 31, data in bits 11:0}, with all other bits 0.
- R4: A read of a result register returns the current word and then clears that channel's valid flag. A later read shows bit 31 as 0 with the data unchanged.
- R5: A sample done pulse on a channel whose valid flag is 1 sets the overwrite flag (raw bit 3). The new data replaces the old and the valid flag stays 1. A read of the same channel in the same cycle consumes the old word, and then no overwrite is flagged.
- R6: The watchdog is switched on by bit 0 at offset 4. The thresholds sit at offset 5: the lower one in bits 11:0 and the upper one in bits 27:16. While the watchdog is on, a result strictly below the lower threshold sets raw bit 4 and a result strictly above the upper threshold sets raw bit 5. Equal values and a watchdog that is off set neither bit.
- R7: Writing 1s to the clear register (offset 3) clears those raw bits, and with them their status bits. The clear register reads as 0.
- R8: When a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: After reset, all flags, valid bits, enables, watchdog settings and thresholds are 0, and `irqReq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| evtSample | input | 1 | Single-channel conversion done pulse |
| evtCh | input | 3 | Channel index of the completed conversion |
| evtData | input | 12 | Result of the completed conversion |
| evtGroup | input | 1 | Subgroup done pulse |
| evtCycle | input | 1 | Cycle done pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe, which consumes a result on a result read |
| regAddr | input | 4 | Register offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the address |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench aims at the values at the exact edges of the threshold window. A design that used inclusive compares would flag 0x100 and 0x800 against a 0x100..0x800 window. It sends a completion pulse in the same cycle as a clear of the same flag: a design that let the clear win would lose the event. It reads a channel in the same cycle that a new result reaches it: a design that ignored the read would flag a false overwrite, or would clear the valid bit of the fresh data. It also drops the enables while raw flags are pending. A design that tied raw flags to the enables would lose those flags, and one that did not mask the request would still raise `irqReq`.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int CH_W   = ADDR_W - 1;
  localparam int NUM_CH = 1 << CH_W;
  localparam int FLAG_N = 6;

  localparam int F_SAMPLE = 0;
  localparam int F_GROUP  = 1;
  localparam int F_CYCLE  = 2;
  localparam int F_OVWR   = 3;
  localparam int F_LOW    = 4;
  localparam int F_HIGH   = 5;

  localparam logic [ADDR_W-1:0] A_EN    = 4'd0;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_WDCTL = 4'd4;
  localparam logic [ADDR_W-1:0] A_THR   = 4'd5;

  typedef struct packed {
    logic [FLAG_N-1:0] clrMask;
    logic              rdData;
    logic [CH_W-1:0]   rdCh;
    logic              wdEn;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_irq_ctl.sv
module adc_irq_ctl
  import adc_irq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic                           regRdEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [31:0]                    regWrData,
  input  logic [FLAG_N-1:0]              rawFlags,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chData,
  input  logic [NUM_CH-1:0]              chValid,
  output logic [31:0]                    regRdData,
  output ctlStrobe_t                     strb,
  output logic [DATA_W-1:0]              thrLo,
  output logic [DATA_W-1:0]              thrHi,
  output logic [FLAG_N-1:0]              enMask,
  output logic                           irqReq
);
  localparam int PAD_W = 31 - DATA_W;
  localparam int HI_LSB = 16;

  logic wdEnReg;
  logic [CH_W-1:0] selCh;
  logic isDataAddr;

  assign selCh = regAddr[CH_W-1:0];
  assign isDataAddr = regAddr[ADDR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask  <= '0;
      wdEnReg <= 1'b0;
      thrLo   <= '0;
      thrHi   <= '0;
    end else if (regWrEn && !isDataAddr) begin
      case (regAddr)
        A_EN:    enMask <= regWrData[FLAG_N-1:0];
        A_WDCTL: wdEnReg <= regWrData[0];
        A_THR: begin
          thrLo <= regWrData[DATA_W-1:0];
          thrHi <= regWrData[HI_LSB +: DATA_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clrMask = (regWrEn && regAddr == A_CLR) ? regWrData[FLAG_N-1:0] : '0;
    strb.rdData  = regRdEn && isDataAddr;
    strb.rdCh    = selCh;
    strb.wdEn    = wdEnReg;
  end

  always_comb begin
    regRdData = '0;
    if (isDataAddr) begin
      regRdData = {chValid[selCh], {PAD_W{1'b0}}, chData[selCh]};
    end else begin
      case (regAddr)
        A_EN:    regRdData[FLAG_N-1:0] = enMask;
        A_RAW:   regRdData[FLAG_N-1:0] = rawFlags;
        A_STAT:  regRdData[FLAG_N-1:0] = rawFlags & enMask;
        A_WDCTL: regRdData[0] = wdEnReg;
        A_THR: begin
          regRdData[DATA_W-1:0] = thrLo;
          regRdData[HI_LSB +: DATA_W] = thrHi;
        end
        default: regRdData = '0;
      endcase
    end
  end

  assign irqReq = |(rawFlags & enMask);

  // R2: an enable write takes effect in the next cycle
  a_r2_enable_written: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == A_EN |=> enMask == $past(regWrData[FLAG_N-1:0]));

  // R6: the thresholds hold their value unless written
  a_r6_thr_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == A_THR) |=> $stable(thrLo) && $stable(thrHi));
endmodule

// File: rtl/adc_irq_dp.sv
module adc_irq_dp
  import adc_irq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           evtSample,
  input  logic [CH_W-1:0]                evtCh,
  input  logic [DATA_W-1:0]              evtData,
  input  logic                           evtGroup,
  input  logic                           evtCycle,
  input  ctlStrobe_t                     strb,
  input  logic [DATA_W-1:0]              thrLo,
  input  logic [DATA_W-1:0]              thrHi,
  output logic [FLAG_N-1:0]              rawFlags,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chData,
  output logic [NUM_CH-1:0]              chValid
);
  logic [FLAG_N-1:0] setMask;
  logic sameChRead;
  logic ovwrHit;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : gCh
    logic hit;
    logic rdHit;
    assign hit   = evtSample && evtCh == CH_W'(gi);
    assign rdHit = strb.rdData && strb.rdCh == CH_W'(gi);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chData[gi]  <= '0;
        chValid[gi] <= 1'b0;
      end else if (hit) begin
        chData[gi]  <= evtData;
        chValid[gi] <= 1'b1;
      end else if (rdHit) begin
        chValid[gi] <= 1'b0;
      end
    end
  end

  assign sameChRead = strb.rdData && strb.rdCh == evtCh;
  assign ovwrHit = evtSample && chValid[evtCh] && !sameChRead;

  always_comb begin
    setMask = '0;
    setMask[F_SAMPLE] = evtSample;
    setMask[F_GROUP]  = evtGroup;
    setMask[F_CYCLE]  = evtCycle;
    setMask[F_OVWR]   = ovwrHit;
    setMask[F_LOW]    = evtSample && strb.wdEn && (evtData < thrLo);
    setMask[F_HIGH]   = evtSample && strb.wdEn && (evtData > thrHi);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawFlags <= '0;
    else       rawFlags <= (rawFlags & ~strb.clrMask) | setMask;
  end

  a_r1_sample_flag: assert property (@(posedge clk) disable iff (!rstN)
    evtSample |=> rawFlags[F_SAMPLE]);
  a_r1_group_flag: assert property (@(posedge clk) disable iff (!rstN)
    evtGroup |=> rawFlags[F_GROUP]);
  a_r1_cycle_flag: assert property (@(posedge clk) disable iff (!rstN)
    evtCycle |=> rawFlags[F_CYCLE]);
  a_r3_result_stored: assert property (@(posedge clk) disable iff (!rstN)
    evtSample |=> chValid[$past(evtCh)] && chData[$past(evtCh)] == $past(evtData));
  a_r4_read_consumes: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdData && !(evtSample && evtCh == strb.rdCh) |=> !chValid[$past(strb.rdCh)]);
  a_r5_overwrite_flag: assert property (@(posedge clk) disable iff (!rstN)
    evtSample && chValid[evtCh] && !(strb.rdData && strb.rdCh == evtCh) |=> rawFlags[F_OVWR]);
  a_r6_low_flag: assert property (@(posedge clk) disable iff (!rstN)
    evtSample && strb.wdEn && evtData < thrLo |=> rawFlags[F_LOW]);
  a_r6_high_flag: assert property (@(posedge clk) disable iff (!rstN)
    evtSample && strb.wdEn && evtData > thrHi |=> rawFlags[F_HIGH]);
  a_r7_clear_group: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMask[F_GROUP] && !evtGroup |=> !rawFlags[F_GROUP]);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMask[F_SAMPLE] && evtSample |=> rawFlags[F_SAMPLE]);
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
  import adc_irq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtSample,
  input  logic [2:0]        evtCh,
  input  logic [DATA_W-1:0] evtData,
  input  logic              evtGroup,
  input  logic              evtCycle,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqReq
);
  ctlStrobe_t strb;
  logic [FLAG_N-1:0] rawFlags;
  logic [FLAG_N-1:0] enMask;
  logic [NUM_CH-1:0][DATA_W-1:0] chData;
  logic [NUM_CH-1:0] chValid;
  logic [DATA_W-1:0] thrLo;
  logic [DATA_W-1:0] thrHi;

  adc_irq_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .rawFlags(rawFlags),
    .chData(chData), .chValid(chValid), .regRdData(regRdData),
    .strb(strb), .thrLo(thrLo), .thrHi(thrHi), .enMask(enMask),
    .irqReq(irqReq)
  );

  adc_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtSample(evtSample), .evtCh(evtCh),
    .evtData(evtData), .evtGroup(evtGroup), .evtCycle(evtCycle),
    .strb(strb), .thrLo(thrLo), .thrHi(thrHi), .rawFlags(rawFlags),
    .chData(chData), .chValid(chValid)
  );

  // R2: an enabled sample completion raises the request in the next cycle
  a_r2_irq_follows_sample: assert property (@(posedge clk) disable iff (!rstN)
    evtSample && enMask[F_SAMPLE] && !(regWrEn && regAddr == A_EN) |=> irqReq);
  // R9: with nothing enabled there is no request
  a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    enMask == '0 |-> !irqReq);
endmodule

// File: tb/sim_adc_irq_ctrl.sv
module sim_adc_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtSample = 1'b0;
  logic [2:0] evtCh = '0;
  logic [11:0] evtData = '0;
  logic evtGroup = 1'b0;
  logic evtCycle = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irqReq;

  typedef struct {
    logic [31:0] exp;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .evtSample(evtSample), .evtCh(evtCh),
    .evtData(evtData), .evtGroup(evtGroup), .evtCycle(evtCycle),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq)
  );

  // monitor: compare every read against the head of the scoreboard
  always @(negedge clk) begin
    if (regRdEn) begin
      expItem_t it;
      nChk++;
      if (sbQ.size() == 0) begin
        nFail++;
        $display("FAIL scoreboard empty: got %h", regRdData);
      end else begin
        it = sbQ.pop_front();
        if (regRdData !== it.exp) begin
          nFail++;
          $display("FAIL %s addr %0d: got %h expected %h", it.tag, regAddr, regRdData, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.exp = e;
    it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk); #1;
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic drive(input logic s, input logic [2:0] ch, input logic [11:0] d,
                       input logic g, input logic c);
    @(posedge clk); #1;
    evtSample = s; evtCh = ch; evtData = d; evtGroup = g; evtCycle = c;
    @(posedge clk); #1;
    evtSample = 1'b0; evtGroup = 1'b0; evtCycle = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(negedge clk);
    nChk++;
    if (irqReq !== e) begin
      nFail++;
      $display("FAIL %s irqReq: got %b expected %b", tag, irqReq, e);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9 reset state
    chkIrq(1'b0, "R9");
    rd(4'd0, 32'h0, "R9 enable");
    rd(4'd1, 32'h0, "R9 raw");
    rd(4'd2, 32'h0, "R9 status");
    rd(4'd11, 32'h0, "R9 result ch3");
    rd(4'd5, 32'h0, "R9 thresholds");

    // R1/R2/R3/R4 single sample
    wr(4'd0, 32'h3F);
    drive(1'b1, 3'd2, 12'h123, 1'b0, 1'b0);
    chkIrq(1'b1, "R2 enabled sample");
    rd(4'd1, 32'h01, "R1 sample flag");
    rd(4'd2, 32'h01, "R2 status");
    rd(4'd10, 32'h8000_0123, "R3 result with valid");
    rd(4'd10, 32'h0000_0123, "R4 valid cleared by read");

    // R7 clear
    wr(4'd3, 32'h01);
    rd(4'd1, 32'h0, "R7 raw cleared");
    rd(4'd2, 32'h0, "R7 status cleared");
    rd(4'd3, 32'h0, "R7 clear reads zero");
    chkIrq(1'b0, "R7 request dropped");

    // R1 group and cycle
    drive(1'b0, 3'd0, 12'h0, 1'b1, 1'b0);
    rd(4'd1, 32'h02, "R1 group flag");
    drive(1'b0, 3'd0, 12'h0, 1'b0, 1'b1);
    rd(4'd1, 32'h06, "R1 cycle flag");
    wr(4'd3, 32'h3F);
    rd(4'd1, 32'h0, "R7 clear all");

    // R5 overwrite
    drive(1'b1, 3'd5, 12'hAAA, 1'b0, 1'b0);
    drive(1'b1, 3'd5, 12'h555, 1'b0, 1'b0);
    rd(4'd1, 32'h09, "R5 overwrite flag");
    rd(4'd13, 32'h8000_0555, "R5 newer data kept");
    rd(4'd13, 32'h0000_0555, "R4 consumed");

    // R2 masking and stickiness
    wr(4'd0, 32'h0);
    chkIrq(1'b0, "R2 masked");
    rd(4'd2, 32'h0, "R2 status masked");
    rd(4'd1, 32'h09, "R2 raw sticky");
    wr(4'd0, 32'h08);
    chkIrq(1'b1, "R2 overwrite only");
    rd(4'd2, 32'h08, "R2 status overwrite only");
    wr(4'd3, 32'h3F);
    wr(4'd0, 32'h3F);

    // R6 watchdog
    wr(4'd5, 32'h0800_0100);
    rd(4'd5, 32'h0800_0100, "R6 thresholds");
    drive(1'b1, 3'd0, 12'h000, 1'b0, 1'b0);
    rd(4'd1, 32'h01, "R6 off: no low flag");
    wr(4'd3, 32'h3F);
    wr(4'd4, 32'h1);
    drive(1'b1, 3'd1, 12'h100, 1'b0, 1'b0);
    rd(4'd1, 32'h01, "R6 equal lower");
    drive(1'b1, 3'd2, 12'h800, 1'b0, 1'b0);
    rd(4'd1, 32'h01, "R6 equal upper");
    drive(1'b1, 3'd3, 12'h0FF, 1'b0, 1'b0);
    rd(4'd1, 32'h11, "R6 below lower");
    wr(4'd3, 32'h3F);
    drive(1'b1, 3'd4, 12'h801, 1'b0, 1'b0);
    rd(4'd1, 32'h21, "R6 above upper");
    wr(4'd3, 32'h3F);

    // R8 set wins over clear
    @(posedge clk); #1;
    evtSample = 1'b1; evtCh = 3'd6; evtData = 12'h200;
    regWrEn = 1'b1; regAddr = 4'd3; regWrData = 32'h01;
    @(posedge clk); #1;
    evtSample = 1'b0; regWrEn = 1'b0; regWrData = '0;
    rd(4'd1, 32'h01, "R8 set wins");
    wr(4'd3, 32'h3F);

    // R5 read of same channel with a new result
    begin
      expItem_t it;
      it.exp = 32'h8000_0200;
      it.tag = "R5 same-cycle read gets old word";
      sbQ.push_back(it);
    end
    @(posedge clk); #1;
    evtSample = 1'b1; evtCh = 3'd6; evtData = 12'h321;
    regRdEn = 1'b1; regAddr = 4'd14;
    @(posedge clk); #1;
    evtSample = 1'b0; regRdEn = 1'b0;
    rd(4'd1, 32'h01, "R5 no overwrite when read");
    rd(4'd14, 32'h8000_0321, "R5 fresh data valid");

    repeat (2) @(posedge clk);
    if (sbQ.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: %0d reads never seen, expected 0", sbQ.size());
    end
    done = 1'b1;
    finishRun();
  end
endmodule